// File: doc/BRIEF.md
# Two-Port Word-Interleaved Banked Memory

This block is a memory with two request ports, built from several single-ported storage banks. Consecutive word addresses fall in consecutive banks. The low bits of a word address select the bank, and the remaining upper bits select the row inside that bank. In each cycle either port may present one request, made of a valid bit, a word address, a write enable and write data.

Requests that land in different banks are served together in the same cycle. When both requests land in the same bank, port 0 always wins. The port 1 request is then dropped, and a replay pulse in the same cycle tells its issuer to send it again later. A dropped request has no effect on storage. A granted read returns its data one cycle after the grant, together with a valid flag for that port.

The bank-select logic is combinational. The issuing stage therefore sees the grant and replay outcome in the cycle it presents a request, and can reschedule the request at once.

Top module: `banked_dual_mem`

## Requirements
- R1: Word address A is stored in bank (A mod NUM_BANKS), row (A / NUM_BANKS). With the defaults (4 banks, 6-bit addresses), the bank is address bits [1:0]. A word written at any address reads back unchanged from either port.
- R2: When both ports are valid and their addresses fall in different banks, p0Grant and p1Grant are both high in that cycle, and p1Replay is low.
- R3: When both ports are valid and their addresses fall in the same bank, p0Grant is high and p1Grant is low in that cycle. A valid port 0 request is always granted.
- R4: p1Replay is high in exactly those cycles where both ports are valid and target the same bank. A replayed write leaves storage unchanged, and a replayed read produces no read-valid.
- R5: A granted read raises that port's rd-valid flag in the following cycle, with the addressed word on that port's read data. Writes, idle cycles and replayed requests leave the flag low in the following cycle.
- R6: During and directly after reset, both rd-valid flags are low. With no valid request, no grant or replay is raised.
- R7: A pair of streams whose addresses differ by a multiple of NUM_BANKS conflicts on every paired access: port 1 is replayed each time.
- R8: A replayed port 1 request, reissued in a cycle without a same-bank port 0 request, is granted and takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p0Valid | input | 1 | Port 0 request present |
| p0Addr | input | ADDR_W | Port 0 word address |
| p0WrEn | input | 1 | Port 0 write (1) or read (0) |
| p0WrData | input | DATA_W | Port 0 write data |
| p1Valid | input | 1 | Port 1 request present |
| p1Addr | input | ADDR_W | Port 1 word address |
| p1WrEn | input | 1 | Port 1 write (1) or read (0) |
| p1WrData | input | DATA_W | Port 1 write data |
| p0Grant | output | 1 | Port 0 request accepted this cycle |
| p1Grant | output | 1 | Port 1 request accepted this cycle |
| p1Replay | output | 1 | Port 1 request cancelled by a bank conflict; reissue |
| p0RdValid | output | 1 | Port 0 read data valid (one cycle after grant) |
| p0RdData | output | DATA_W | Port 0 read data |
| p1RdValid | output | 1 | Port 1 read data valid (one cycle after grant) |
| p1RdData | output | DATA_W | Port 1 read data |

## Verification
Grants and replay are combinational. The bench drives a request on the falling edge and samples p0Grant, p1Grant and p1Replay one nanosecond later, before the rising edge that commits the access. Read-valid flags and read data come one register stage after the grant. They are sampled at the next falling edge and compared with a reference array, whose write updates are applied only after that sample. A write and a read in the same cycle always target different banks, so the order of those updates does not affect the expected data.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic p0Go;  // port 0 accesses its bank this cycle
    logic p1Go;  // port 1 accesses its bank this cycle
    logic p0Rd;  // port 0 access is a read
    logic p1Rd;  // port 1 access is a read
  } bmem_strobe_t;
endpackage

// File: rtl/bmem_ctrl.sv
module bmem_ctrl
  import bmem_pkg::*;
#(
  parameter int BANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 p0Valid,
  input  logic                 p0WrEn,
  input  logic [BANK_BITS-1:0] p0Bank,
  input  logic                 p1Valid,
  input  logic                 p1WrEn,
  input  logic [BANK_BITS-1:0] p1Bank,
  output bmem_strobe_t         strobe,
  output logic                 p0Grant,
  output logic                 p1Grant,
  output logic                 p1Replay,
  output logic                 p0RdValid,
  output logic                 p1RdValid
);
  logic sameBank;

  always_comb begin
    sameBank     = p0Valid && p1Valid && (p0Bank == p1Bank);
    p0Grant      = p0Valid;              // fixed priority for port 0
    p1Grant      = p1Valid && !sameBank;
    p1Replay     = sameBank;
    strobe.p0Go  = p0Grant;
    strobe.p1Go  = p1Grant;
    strobe.p0Rd  = p0Grant && !p0WrEn;
    strobe.p1Rd  = p1Grant && !p1WrEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0RdValid <= 1'b0;
      p1RdValid <= 1'b0;
    end else begin
      p0RdValid <= strobe.p0Rd;
      p1RdValid <= strobe.p1Rd;
    end
  end
endmodule

// File: rtl/bmem_datapath.sv
module bmem_datapath
  import bmem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 16,
  parameter int DATA_W    = 32,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int ROW_BITS  = $clog2(ROWS)
) (
  input  logic                 clk,
  input  bmem_strobe_t         strobe,
  input  logic [BANK_BITS-1:0] p0Bank,
  input  logic [ROW_BITS-1:0]  p0Row,
  input  logic [DATA_W-1:0]    p0WrData,
  input  logic [BANK_BITS-1:0] p1Bank,
  input  logic [ROW_BITS-1:0]  p1Row,
  input  logic [DATA_W-1:0]    p1WrData,
  output logic [DATA_W-1:0]    p0RdData,
  output logic [DATA_W-1:0]    p1RdData
);
  logic [DATA_W-1:0]    bankOut [NUM_BANKS];
  logic [BANK_BITS-1:0] p0SelQ, p1SelQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] readQ;
    logic              use0, use1;

    always_comb begin
      use0 = strobe.p0Go && (p0Bank == BANK_BITS'(b));
      use1 = strobe.p1Go && (p1Bank == BANK_BITS'(b));
    end

    // Single port per bank: control never grants both ports the same bank.
    always_ff @(posedge clk) begin
      if (use0) begin
        if (strobe.p0Rd) readQ <= mem[p0Row];
        else             mem[p0Row] <= p0WrData;
      end else if (use1) begin
        if (strobe.p1Rd) readQ <= mem[p1Row];
        else             mem[p1Row] <= p1WrData;
      end
    end

    assign bankOut[b] = readQ;
  end

  always_ff @(posedge clk) begin
    if (strobe.p0Rd) p0SelQ <= p0Bank;
    if (strobe.p1Rd) p1SelQ <= p1Bank;
  end

  assign p0RdData = bankOut[p0SelQ];
  assign p1RdData = bankOut[p1SelQ];
endmodule

// File: rtl/banked_dual_mem.sv
module banked_dual_mem
  import bmem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int ROW_BITS  = ADDR_W - BANK_BITS,
  localparam int ROWS      = 1 << ROW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0Valid,
  input  logic [ADDR_W-1:0] p0Addr,
  input  logic              p0WrEn,
  input  logic [DATA_W-1:0] p0WrData,
  input  logic              p1Valid,
  input  logic [ADDR_W-1:0] p1Addr,
  input  logic              p1WrEn,
  input  logic [DATA_W-1:0] p1WrData,
  output logic              p0Grant,
  output logic              p1Grant,
  output logic              p1Replay,
  output logic              p0RdValid,
  output logic [DATA_W-1:0] p0RdData,
  output logic              p1RdValid,
  output logic [DATA_W-1:0] p1RdData
);
  // Bank = low word-address bits (power-of-two bank count, at least 2).
  logic [BANK_BITS-1:0] p0Bank, p1Bank;
  logic [ROW_BITS-1:0]  p0Row,  p1Row;
  bmem_strobe_t         strobe;

  assign p0Bank = p0Addr[BANK_BITS-1:0];
  assign p1Bank = p1Addr[BANK_BITS-1:0];
  assign p0Row  = p0Addr[ADDR_W-1:BANK_BITS];
  assign p1Row  = p1Addr[ADDR_W-1:BANK_BITS];

  bmem_ctrl #(.BANK_BITS(BANK_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .p0Valid(p0Valid), .p0WrEn(p0WrEn), .p0Bank(p0Bank),
    .p1Valid(p1Valid), .p1WrEn(p1WrEn), .p1Bank(p1Bank),
    .strobe(strobe),
    .p0Grant(p0Grant), .p1Grant(p1Grant), .p1Replay(p1Replay),
    .p0RdValid(p0RdValid), .p1RdValid(p1RdValid)
  );

  bmem_datapath #(.NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .strobe(strobe),
    .p0Bank(p0Bank), .p0Row(p0Row), .p0WrData(p0WrData),
    .p1Bank(p1Bank), .p1Row(p1Row), .p1WrData(p1WrData),
    .p0RdData(p0RdData), .p1RdData(p1RdData)
  );
endmodule

// File: rtl/bmem_chk.sv
module bmem_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 6,
  localparam int BANK_BITS = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              p0Valid,
  input logic [ADDR_W-1:0] p0Addr,
  input logic              p0WrEn,
  input logic              p1Valid,
  input logic [ADDR_W-1:0] p1Addr,
  input logic              p1WrEn,
  input logic              p0Grant,
  input logic              p1Grant,
  input logic              p1Replay,
  input logic              p0RdValid,
  input logic              p1RdValid
);
  logic hit;
  assign hit = p0Addr[BANK_BITS-1:0] == p1Addr[BANK_BITS-1:0];

  AST_DIFF_BANK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (p0Valid && p1Valid && !hit) |-> (p0Grant && p1Grant && !p1Replay)); // R2
  AST_PORT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (p0Valid && p1Valid && hit) |-> (p0Grant && !p1Grant)); // R3
  AST_REPLAY_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    p1Replay |-> (p1Valid && p0Valid && hit && !p1Grant)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !p1Valid |-> (!p1Grant && !p1Replay)); // R6
  AST_RD0_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (p0Valid && !p0WrEn) |=> p0RdValid); // R5
  AST_RD1_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (p1Grant && !p1WrEn) |=> p1RdValid); // R5
  AST_NO_RD1_AFTER_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    p1Replay |=> !p1RdValid); // R4
endmodule

bind banked_dual_mem bmem_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .p0Valid(p0Valid), .p0Addr(p0Addr), .p0WrEn(p0WrEn),
  .p1Valid(p1Valid), .p1Addr(p1Addr), .p1WrEn(p1WrEn),
  .p0Grant(p0Grant), .p1Grant(p1Grant), .p1Replay(p1Replay),
  .p0RdValid(p0RdValid), .p1RdValid(p1RdValid)
);

// File: tb/banked_dual_mem_tb.sv
`timescale 1ns/1ps
module banked_dual_mem_tb;
  localparam int NB    = 4;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0Valid = 0, p0WrEn = 0, p1Valid = 0, p1WrEn = 0;
  logic [AW-1:0] p0Addr = '0, p1Addr = '0;
  logic [DW-1:0] p0WrData = '0, p1WrData = '0;
  logic p0Grant, p1Grant, p1Replay, p0RdValid, p1RdValid;
  logic [DW-1:0] p0RdData, p1RdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [DW-1:0] refMem [DEPTH];

  always #2.5 clk = ~clk;

  banked_dual_mem #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .p0Valid(p0Valid), .p0Addr(p0Addr), .p0WrEn(p0WrEn), .p0WrData(p0WrData),
    .p1Valid(p1Valid), .p1Addr(p1Addr), .p1WrEn(p1WrEn), .p1WrData(p1WrData),
    .p0Grant(p0Grant), .p1Grant(p1Grant), .p1Replay(p1Replay),
    .p0RdValid(p0RdValid), .p0RdData(p0RdData),
    .p1RdValid(p1RdValid), .p1RdData(p1RdData)
  );

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle with both ports; expected outcome from the requirements.
  task automatic pairOp(string tag,
                        bit v0, int a0, bit w0, logic [DW-1:0] d0,
                        bit v1, int a1, bit w1, logic [DW-1:0] d1);
    bit clash, eg0, eg1;
    logic [DW-1:0] er0, er1;
    clash = v0 && v1 && ((a0 % NB) == (a1 % NB));
    eg0 = v0;
    eg1 = v1 && !clash;
    er0 = refMem[a0 % DEPTH];
    er1 = refMem[a1 % DEPTH];
    p0Valid = v0; p0Addr = AW'(a0); p0WrEn = w0; p0WrData = d0;
    p1Valid = v1; p1Addr = AW'(a1); p1WrEn = w1; p1WrData = d1;
    #1;
    chk(tag, "p0Grant", DW'(p0Grant), DW'(eg0));
    chk(tag, "p1Grant", DW'(p1Grant), DW'(eg1));
    chk(tag, "p1Replay", DW'(p1Replay), DW'(clash));
    @(negedge clk);
    chk(tag, "p0RdValid", DW'(p0RdValid), DW'(eg0 && !w0));
    chk(tag, "p1RdValid", DW'(p1RdValid), DW'(eg1 && !w1));
    if (eg0 && !w0) chk(tag, "p0RdData", p0RdData, er0);
    if (eg1 && !w1) chk(tag, "p1RdData", p1RdData, er1);
    if (eg0 && w0) refMem[a0 % DEPTH] = d0;
    if (eg1 && w1) refMem[a1 % DEPTH] = d1;
    p0Valid = 0; p1Valid = 0; p0WrEn = 0; p1WrEn = 0;
  endtask

  task automatic testReset();
    chk("R6", "p0RdValid after reset", DW'(p0RdValid), 0);
    chk("R6", "p1RdValid after reset", DW'(p1RdValid), 0);
    chk("R6", "p1Grant idle", DW'(p1Grant), 0);
    chk("R6", "p1Replay idle", DW'(p1Replay), 0);
  endtask

  task automatic testFill();  // R2: neighbouring words sit in different banks
    for (int i = 0; i < DEPTH; i += 2)
      pairOp("R2", 1, i, 1, 32'hA500_0000 + DW'(i), 1, i + 1, 1, 32'h5A00_0000 + DW'(i + 1));
  endtask

  task automatic testReadBack();  // R1 mapping, R5 latency, mixed orders
    for (int i = 0; i < DEPTH; i += 2)
      pairOp("R1", 1, i + 1, 0, '0, 1, i, 0, '0);
    for (int i = 0; i < 16; i++)
      pairOp("R5", 1, (i * 7) % DEPTH, 0, '0, 1, (i * 7 + 2) % DEPTH, 0, '0);
  endtask

  task automatic testMixed();  // R2: write on one port, read on other
    pairOp("R2", 1, 12, 1, 32'hCAFE_0012, 1, 13, 0, '0);
    pairOp("R2", 1, 14, 0, '0, 1, 12, 0, '0);
    pairOp("R5", 0, 0, 0, '0, 0, 0, 0, '0);
  endtask

  task automatic testConflict();  // R3, R4, R8
    pairOp("R4", 1, 5, 1, 32'h1111_0005, 1, 9, 1, 32'h2222_0009);
    pairOp("R4", 1, 9, 0, '0, 0, 0, 0, '0);          // 9 unchanged
    pairOp("R3", 1, 21, 0, '0, 1, 21, 0, '0);        // same address read
    pairOp("R8", 0, 0, 0, '0, 1, 9, 1, 32'h2222_0009); // reissue alone
    pairOp("R8", 1, 10, 0, '0, 1, 9, 0, '0);
    pairOp("R3", 1, 3, 1, 32'h3333_0003, 1, 3, 0, '0); // write wins, read replayed
    pairOp("R3", 0, 0, 0, '0, 1, 3, 0, '0);
  endtask

  task automatic testStride();  // R7: stride multiple of bank count
    for (int i = 0; i < 8; i++)
      pairOp("R7", 1, (i * NB) % DEPTH, 0, '0, 1, ((i + 1) * NB) % DEPTH, 0, '0);
    for (int i = 0; i < 8; i++)
      pairOp("R7", 1, (i * 2 * NB + 1) % DEPTH, 0, '0, 1, ((i + 3) * 2 * NB + 1) % DEPTH, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testFill();
    testReadBack();
    testMixed();
    testConflict();
    testStride();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule